// File: doc/BRIEF.md
# Pipelined ADC Code Gap Corrector

This block linearizes the output of a pipelined converter whose first few stages leave missing-code gaps, or overlapping codes, where their bit decisions switch. Each sample comes in as the raw shift-and-add reconstruction. With it come the decision bits of the calibrated stages and a set of signed integer gap estimates, one for each decision boundary. A sample that lies above a boundary gets that boundary's gap subtracted. A sample below it passes through unchanged.

Correction runs in a fixed order. It starts at the deepest calibrated stage and works stage by stage toward the first stage. Each step works on the sample already corrected by the step before it, and one register sits after each step. Stages deeper than the calibrated set are treated as linear, and their bits in the raw code are never touched.

Each stage can be built in one of two forms. A 1.5-bit stage has two comparators, each with its own gap. A 1-bit stage has one comparator. A separate build choice decides whether negative gaps are honoured: with redundancy they are, and without it any negative estimate is read as zero. The output is signed and one bit wider than the raw code.

Top module: `gapcorr_chain`

## Requirements
- R1: While reset is asserted and after it is released, until the first sample emerges, `out_valid` is 0 and `out_sample` is 0.
- R2: For calibrated stage s (stage 1 is s=0), bit `in_dec[2s]` is the lower-boundary comparator. When that bit is 0 and, in 1.5-bit form, `in_dec[2s+1]` is also 0, the stage leaves the sample unchanged. When `in_dec[2s]` is 1, the stage subtracts the gap in slot 2s.
- R3: In 1.5-bit form (HALF_BIT=1), `in_dec[2s+1]` is the upper-boundary comparator. When it is 1, the stage subtracts the gap in slot 2s+1, independently of the lower boundary. Gap slot i occupies `in_gap[i*GAP_W +: GAP_W]` as a two's-complement integer.
- R4: With redundancy (REDUNDANT=1), a negative gap is honoured, so the sample rises by the gap's magnitude.
- R5: Without redundancy (REDUNDANT=0), a negative gap has no effect, and a stage never increases the sample.
- R6: The output equals the zero-extended raw code minus every selected gap. The subtraction for stage NCAL-1 is done first and the one for stage 1 last. The output is a signed value RAW_W+1 bits wide.
- R7: A sample presented with `in_valid` high appears on `out_sample`, with `out_valid` high, exactly NCAL clock cycles later. One sample can be accepted every cycle.
- R8: When `out_valid` is 0, `out_sample` holds the last value it produced.
- R9: After each stage's subtraction, the result saturates to the range -2^RAW_W to 2^RAW_W-1 instead of wrapping.
- R10: In 1-bit form (HALF_BIT=0), `in_dec[2s+1]` and gap slot 2s+1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Raw sample present this cycle |
| in_raw | input | RAW_W | Raw reconstructed code, unsigned |
| in_dec | input | 2*NCAL | Comparator decisions, two per calibrated stage |
| in_gap | input | 2*NCAL*GAP_W | Signed gap estimates, one slot per boundary |
| out_valid | output | 1 | Corrected sample present |
| out_sample | output | RAW_W+1 | Corrected sample, two's complement |

## Verification
A sample and its decisions, driven before clock edge n, produce their corrected result after edge n+NCAL-1. With NCAL=3, that result is due on the falling edge three cycles after the falling edge on which the inputs were driven. The bench records each driven sample's expected value, tagged with its cycle. On every falling edge it compares the outputs against the entry recorded NCAL cycles earlier, and compares against the held value when that entry was idle.

Gap estimates change only after the pipeline has drained, so every sample in flight sees the gaps it was scored with. A second instance, built in 1-bit form without redundancy, receives the same stimulus. It shows that the upper decisions have no effect and that negative gaps are clamped to zero.

// File: rtl/gapcorr_pkg.sv
package gapcorr_pkg;
  localparam int BND_PER_STAGE = 2;
  localparam int BND_LO        = 0;
  localparam int BND_HI        = 1;
endpackage

// File: rtl/gapcorr_gapsel.sv
module gapcorr_gapsel #(
  parameter int GAP_W     = 8,
  parameter int HALF_BIT  = 1,
  parameter int REDUNDANT = 1
) (
  input  logic [1:0]              dec2,
  input  logic signed [GAP_W-1:0] gap_lo,
  input  logic signed [GAP_W-1:0] gap_hi,
  output logic signed [GAP_W+1:0] amt
);
  localparam int AW = GAP_W + 2;

  logic signed [GAP_W-1:0] eff_lo;
  logic signed [GAP_W-1:0] eff_hi;
  logic signed [AW-1:0]    term_lo;
  logic signed [AW-1:0]    term_hi;

  generate
    if (REDUNDANT != 0) begin : g_signed
      assign eff_lo = gap_lo;
      assign eff_hi = gap_hi;
    end else begin : g_clamp
      assign eff_lo = gap_lo[GAP_W-1] ? '0 : gap_lo;
      assign eff_hi = gap_hi[GAP_W-1] ? '0 : gap_hi;
    end
  endgenerate

  always_comb begin
    term_lo = '0;
    if (dec2[0]) term_lo = $signed({{(AW-GAP_W){eff_lo[GAP_W-1]}}, eff_lo});
  end

  generate
    if (HALF_BIT != 0) begin : g_two_cmp
      always_comb begin
        term_hi = '0;
        if (dec2[1]) term_hi = $signed({{(AW-GAP_W){eff_hi[GAP_W-1]}}, eff_hi});
      end
    end else begin : g_one_cmp
      assign term_hi = '0;
    end
  endgenerate

  assign amt = term_lo + term_hi;
endmodule

// File: rtl/gapcorr_stage.sv
module gapcorr_stage
  import gapcorr_pkg::*;
#(
  parameter int SW        = 13,
  parameter int GAP_W     = 8,
  parameter int DEC_W     = 6,
  parameter int STG       = 0,
  parameter int HALF_BIT  = 1,
  parameter int REDUNDANT = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [SW-1:0]    in_sample,
  input  logic [DEC_W-1:0]        in_dec,
  input  logic signed [GAP_W-1:0] gap_lo,
  input  logic signed [GAP_W-1:0] gap_hi,
  output logic                    out_valid,
  output logic signed [SW-1:0]    out_sample,
  output logic [DEC_W-1:0]        out_dec
);
  localparam int AW = GAP_W + 2;
  localparam int WW = SW + 1;
  localparam logic signed [SW-1:0] SMAX = {1'b0, {(SW-1){1'b1}}};
  localparam logic signed [SW-1:0] SMIN = {1'b1, {(SW-1){1'b0}}};

  logic [1:0]           my_dec;
  logic signed [AW-1:0] amt;
  logic signed [WW-1:0] wide;
  logic signed [SW-1:0] smp_d;
  logic signed [SW-1:0] smp_q;
  logic [DEC_W-1:0]     dec_q;
  logic                 valid_q;

  assign my_dec = in_dec[BND_PER_STAGE*STG +: BND_PER_STAGE];

  gapcorr_gapsel #(
    .GAP_W(GAP_W), .HALF_BIT(HALF_BIT), .REDUNDANT(REDUNDANT)
  ) u_sel (
    .dec2(my_dec), .gap_lo(gap_lo), .gap_hi(gap_hi), .amt(amt)
  );

  always_comb begin
    wide = $signed({in_sample[SW-1], in_sample})
         - $signed({{(WW-AW){amt[AW-1]}}, amt});
    if (wide[WW-1] != wide[WW-2]) smp_d = wide[WW-1] ? SMIN : SMAX;
    else                          smp_d = wide[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      smp_q   <= '0;
      dec_q   <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        smp_q <= smp_d;
        dec_q <= in_dec;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_sample = smp_q;
  assign out_dec    = dec_q;

  // R2
  no_dec_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && my_dec == 2'b00) |=> smp_q == $past(in_sample));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(smp_q) && !valid_q));

  // R9
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sample == SMAX && amt < 0) |=> smp_q == SMAX);

  generate
    if (REDUNDANT == 0) begin : g_chk_clamp
      // R5
      never_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> smp_q <= $past(in_sample));
    end
    if (HALF_BIT == 0) begin : g_chk_one
      // R10
      upper_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !my_dec[BND_LO]) |=> smp_q == $past(in_sample));
    end
  endgenerate
endmodule

// File: rtl/gapcorr_chain.sv
module gapcorr_chain
  import gapcorr_pkg::*;
#(
  parameter int RAW_W     = 12,
  parameter int GAP_W     = 8,
  parameter int NCAL      = 3,
  parameter int HALF_BIT  = 1,
  parameter int REDUNDANT = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [RAW_W-1:0]               in_raw,
  input  logic [BND_PER_STAGE*NCAL-1:0]  in_dec,
  input  logic [BND_PER_STAGE*NCAL*GAP_W-1:0] in_gap,
  output logic                           out_valid,
  output logic signed [RAW_W:0]          out_sample
);
  localparam int SW    = RAW_W + 1;
  localparam int DEC_W = BND_PER_STAGE * NCAL;

  logic                 vld [0:NCAL];
  logic signed [SW-1:0] smp [0:NCAL];
  logic [DEC_W-1:0]     dec [0:NCAL-1];
  logic [DEC_W-1:0]     dec_last;

  assign vld[0] = in_valid;
  assign smp[0] = $signed({1'b0, in_raw});
  assign dec[0] = in_dec;

  genvar p;
  generate
    for (p = 0; p < NCAL; p++) begin : g_pos
      localparam int S = NCAL - 1 - p;
      logic [DEC_W-1:0] dec_o;

      gapcorr_stage #(
        .SW(SW), .GAP_W(GAP_W), .DEC_W(DEC_W), .STG(S),
        .HALF_BIT(HALF_BIT), .REDUNDANT(REDUNDANT)
      ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (vld[p]),
        .in_sample (smp[p]),
        .in_dec    (dec[p]),
        .gap_lo    (in_gap[(BND_PER_STAGE*S+BND_LO)*GAP_W +: GAP_W]),
        .gap_hi    (in_gap[(BND_PER_STAGE*S+BND_HI)*GAP_W +: GAP_W]),
        .out_valid (vld[p+1]),
        .out_sample(smp[p+1]),
        .out_dec   (dec_o)
      );

      if (p < NCAL - 1) begin : g_fwd
        assign dec[p+1] = dec_o;
      end else begin : g_tail
        assign dec_last = dec_o;
      end
    end
  endgenerate

  assign out_valid  = vld[NCAL];
  assign out_sample = smp[NCAL];

  // R6
  no_dec_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dec_last == '0) |-> !out_sample[RAW_W]);
endmodule

// File: tb/gapcorr_chain_tb.sv
module gapcorr_chain_tb;
  localparam int RAW_W = 12;
  localparam int GAP_W = 8;
  localparam int NCAL  = 3;
  localparam int DW    = 2 * NCAL;
  localparam int GW    = 2 * NCAL * GAP_W;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [RAW_W-1:0] in_raw;
  logic [DW-1:0] in_dec;
  logic [GW-1:0] in_gap;
  logic va, vb;
  logic signed [RAW_W:0] sa, sb;

  always #2 clk = ~clk;

  gapcorr_chain u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_raw(in_raw),
    .in_dec(in_dec), .in_gap(in_gap), .out_valid(va), .out_sample(sa)
  );

  gapcorr_chain #(.HALF_BIT(0), .REDUNDANT(0)) u_dut_nr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_raw(in_raw),
    .in_dec(in_dec), .in_gap(in_gap), .out_valid(vb), .out_sample(sb)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  bit hv [16];
  int hea [16];
  int heb [16];
  string hrq [16];
  int last_a = 0;
  int last_b = 0;

  function automatic int model(int raw, logic [DW-1:0] d, logic [GW-1:0] gv, bit hb, bit rd);
    int acc = raw;
    for (int s = NCAL - 1; s >= 0; s--) begin
      for (int b = 0; b < 2; b++) begin
        int g;
        g = int'($signed(gv[(2*s+b)*GAP_W +: GAP_W]));
        if (!rd && g < 0) g = 0;
        if (d[2*s+b] && (b == 0 || hb)) acc = acc - g;
      end
      if (acc > 4095) acc = 4095;
      if (acc < -4096) acc = -4096;
    end
    return acc;
  endfunction

  function automatic logic [GW-1:0] pack(int g0, int g1, int g2, int g3, int g4, int g5);
    logic [GW-1:0] v;
    v[0*GAP_W +: GAP_W] = g0[GAP_W-1:0];
    v[1*GAP_W +: GAP_W] = g1[GAP_W-1:0];
    v[2*GAP_W +: GAP_W] = g2[GAP_W-1:0];
    v[3*GAP_W +: GAP_W] = g3[GAP_W-1:0];
    v[4*GAP_W +: GAP_W] = g4[GAP_W-1:0];
    v[5*GAP_W +: GAP_W] = g5[GAP_W-1:0];
    return v;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic step(bit v, int raw, logic [DW-1:0] d, string req);
    int idx;
    @(negedge clk);
    cyc++;
    if (cyc > NCAL) begin
      idx = (cyc - NCAL) & 15;
      if (hv[idx]) begin
        last_a = hea[idx];
        last_b = heb[idx];
      end
      chk("R7", "valid a", int'(va), int'(hv[idx]));
      chk("R7", "valid b", int'(vb), int'(hv[idx]));
      chk(hv[idx] ? hrq[idx] : "R8", "sample a", int'(sa), last_a);
      chk(hv[idx] ? hrq[idx] : "R8", "sample b", int'(sb), last_b);
    end
    in_valid = v;
    in_raw   = raw[RAW_W-1:0];
    in_dec   = d;
    hv[cyc & 15]  = v;
    hea[cyc & 15] = model(raw, d, in_gap, 1'b1, 1'b1);
    heb[cyc & 15] = model(raw, d, in_gap, 1'b0, 1'b0);
    hrq[cyc & 15] = req;
  endtask

  task automatic set_gaps(logic [GW-1:0] gv);
    for (int i = 0; i < NCAL + 1; i++) step(1'b0, 0, '0, "R8");
    in_gap = gv;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      hv[i] = 1'b0; hea[i] = 0; heb[i] = 0; hrq[i] = "R1";
    end
    rst_n = 1'b0; in_valid = 1'b0; in_raw = '0; in_dec = '0; in_gap = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset valid a", int'(va), 0);
    chk("R1", "reset sample a", int'(sa), 0);
    chk("R1", "reset valid b", int'(vb), 0);
    chk("R1", "reset sample b", int'(sb), 0);
    rst_n = 1'b1;

    set_gaps(pack(10, -5, 20, 7, 3, -9));
    step(1'b1, 1000, 6'b000000, "R6");
    step(1'b1, 1000, 6'b000001, "R2");
    step(1'b1, 1000, 6'b000010, "R4");
    step(1'b1, 1000, 6'b110000, "R3");
    step(1'b1, 1000, 6'b010000, "R2");
    step(1'b1, 2000, 6'b001100, "R3");
    step(1'b1, 1500, 6'b101010, "R10");
    step(1'b0, 0, 6'b111111, "R8");
    step(1'b0, 7, 6'b000001, "R8");
    step(1'b1, 4095, 6'b111111, "R6");

    set_gaps(pack(-128, -128, -128, -128, -128, -128));
    step(1'b1, 4095, 6'b111111, "R9");
    step(1'b1, 100, 6'b010101, "R5");
    step(1'b1, 4000, 6'b000001, "R9");

    set_gaps(pack(127, 127, 127, 127, 127, 127));
    step(1'b1, 0, 6'b111111, "R6");
    step(1'b1, 5, 6'b000001, "R2");

    for (int r = 0; r < 20; r++) begin
      set_gaps({$urandom(), $urandom()});
      for (int i = 0; i < 150; i++) begin
        step(($urandom() % 4) != 0, int'($urandom() % 4096), $urandom(), "R7");
      end
    end
    for (int i = 0; i < NCAL + 2; i++) step(1'b0, 0, '0, "R8");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule